// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus with open-drain signalling. It holds a small bank of 8-bit configuration registers. Every register powers up to a value set by a parameter, so a system that never talks to the block still sees a defined configuration on the parallel register bus. A controller can change or inspect the bank one register at a time, or walk through the bank as a block. Both bus lines are oversampled by the system clock, so the controller's SCL never clocks any flop directly. The block drives SDA only by pulling it low through `sda_oe`.

A write transaction carries the device address, a command byte and data. If the command byte has its top bit set, it selects single-register access, and its low seven bits give the offset. If the top bit is clear, the command selects block access starting at offset 0, and the low seven bits must be zero. In a block write, the first data byte is a count and the register bytes follow it. A read uses the command left by the most recent accepted command byte. A byte read returns one register. A block read returns the bank size first, then the registers in ascending order.

The controller is a state machine with these states. IDLE waits for START. ADDR shifts in the address byte and ADDR_ACK answers it. CMD shifts in the command and CMD_ACK answers it. WDATA shifts in a data byte and WDATA_ACK answers it. RDATA shifts a byte out and RACK samples the controller's acknowledge. The transitions are as follows:
- START in any state goes to ADDR, and STOP in any state goes to IDLE.
- The eighth rising SCL edge moves each shift state to its answer state, or RDATA to RACK.
- At the end of the acknowledge clock, a NACKed byte goes to IDLE. An acknowledged address goes to CMD for a write or to RDATA for a read. An acknowledged CMD or WDATA byte goes to WDATA.
- RACK goes to RDATA if the controller acknowledged and more bytes remain; otherwise it goes to IDLE.

Top module: `smb_cfg_slave`

## Requirements
- R1: While reset is asserted and right after it, register k on `regs_o` (bits 8k+7:8k) equals byte k of `DEFAULTS`, and `sda_oe` is low.
- R2: Only the 7-bit address 69h is acknowledged, i.e. address byte D2h for a write and D3h for a read; any other address gets a NACK and changes no register.
- R3: A command byte with bit 7 = 1 selects byte access at offset bits 6:0; it is acknowledged only if that offset is below the bank size, otherwise NACKed.
- R4: A command byte with bit 7 = 0 selects block access; it is NACKed unless bits 6:0 are all zero.
- R5: In byte mode, the first data byte after the command is written to the selected register; every further data byte in that transaction is NACKed and written nowhere.
- R6: In block mode, the first data byte is a count; following bytes are written to offsets 0, 1, 2, ... and acknowledged while fewer than the count and fewer than the bank size have been written; any byte past either limit is NACKed and not written.
- R7: A byte read returns the register at the offset of the last accepted byte-mode command.
- R8: A block read returns the bank size as its first byte, then registers from offset 0 upward, continuing while the controller acknowledges; a controller NACK or the last register ends the read.
- R9: Bytes are shifted most significant bit first in both directions, and `sda_oe` changes only while SCL is low.
- R10: A STOP after any complete, acknowledged data byte keeps every byte written so far.
- R11: A START or STOP inside a byte abandons it. No bit of the partial byte reaches a register, `sda_oe` is released, and the next START begins a fresh address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset, loads the defaults |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| sda_oe | output | 1 | Pulls the data line low when high |
| regs_o | output | NREG*8 | Parallel image of the register bank, register k at bits 8k+7:8k |

## Verification
The checker watches four properties on every cycle:
- the reset image of the bank (R1),
- that the block moves SDA only while SCL is low (R9),
- that a STOP always releases the line (R11),
- that the bank changes only on the clock edge that completes a bit (R11).

The address filter, command decode, count and bank limits, read ordering and mid-byte aborts are transaction-level behaviours. Only the bench's scenarios can show them. The bench drives the scenarios against a behavioural register model, compares the bank with that model every clock, and checks every acknowledge bit and every read byte.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } smb_state_e;

endpackage

// File: rtl/smb_line_watch.sv
// Oversamples both bus lines and derives edge and bus-condition strobes.
module smb_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_m, scl_s, scl_p;
    logic sda_m, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            scl_s <= 1'b1;
            scl_p <= 1'b1;
            sda_m <= 1'b1;
            sda_s <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_m <= scl_i;
            scl_s <= scl_m;
            scl_p <= scl_s;
            sda_m <= sda_i;
            sda_s <= sda_m;
            sda_p <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_cfg_regbank.sv
// Register bank with parameter defaults, one write port and one read port.
module smb_cfg_regbank #(
    parameter int unsigned        NREG     = 8,
    parameter int unsigned        AW       = 3,
    parameter logic [NREG*8-1:0]  DEFAULTS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [7:0]        wdata,
    input  logic [AW-1:0]     raddr,
    output logic [7:0]        rdata,
    output logic [NREG*8-1:0] regs_o
);
    logic [7:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= DEFAULTS[g*8 +: 8];
            else if (we && waddr == AW'(g))
                mem[g] <= wdata;
        end
        assign regs_o[g*8 +: 8] = mem[g];
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int unsigned       NREG     = 8,
    parameter logic [6:0]        DEV_ADDR = 7'h69,
    parameter logic [NREG*8-1:0] DEFAULTS = 64'h81A53CC3F00FE718
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] regs_o
);
    localparam int unsigned AW    = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int unsigned RW    = $clog2(NREG + 1);
    localparam logic [6:0]  NREG7 = 7'(NREG);
    localparam logic [7:0]  NREG8 = 8'(NREG);
    localparam logic [RW-1:0] NREGR = RW'(NREG);

    logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    smb_line_watch u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smb_state_e    state_q, state_d;
    logic [2:0]    bit_cnt_q;
    logic [6:0]    rx_sr_q;
    logic [7:0]    tx_sr_q;
    logic          phase_q, ack_ok_q, rw_q, m_ack_q;
    logic          byte_mode_q, cnt_seen_q;
    logic [AW-1:0] ptr_q;
    logic [7:0]    wcnt_q, widx_q;
    logic [RW-1:0] ridx_q;

    logic [7:0]    rx_byte, rdata;
    logic          byte_done, ack_end, cmd_ok, w_accept, wr_en, rd_more;
    logic [AW-1:0] waddr, raddr;

    assign rx_byte   = {rx_sr_q, sda_s};
    assign byte_done = scl_rise && (bit_cnt_q == 3'd7);
    assign ack_end   = scl_fall && phase_q;
    assign cmd_ok    = rx_byte[7] ? (rx_byte[6:0] < NREG7) : (rx_byte[6:0] == 7'd0);
    assign w_accept  = byte_mode_q ? !cnt_seen_q
                                   : (!cnt_seen_q || (widx_q < wcnt_q && widx_q < NREG8));
    assign wr_en     = (state_q == ST_WDATA) && byte_done && w_accept
                       && (byte_mode_q || cnt_seen_q);
    assign waddr     = byte_mode_q ? ptr_q : widx_q[AW-1:0];
    assign raddr     = byte_mode_q ? ptr_q : ridx_q[AW-1:0];
    assign rd_more   = !byte_mode_q && (ridx_q < NREGR);

    smb_cfg_regbank #(.NREG(NREG), .AW(AW), .DEFAULTS(DEFAULTS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en),
        .waddr  (waddr),
        .wdata  (rx_byte),
        .raddr  (raddr),
        .rdata  (rdata),
        .regs_o (regs_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_ev)
            state_d = ST_ADDR;
        else if (stop_ev)
            state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (byte_done) state_d = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (ack_end)   state_d = !ack_ok_q ? ST_IDLE :
                                                        (rw_q ? ST_RDATA : ST_CMD);
                ST_CMD:       if (byte_done) state_d = ST_CMD_ACK;
                ST_CMD_ACK:   if (ack_end)   state_d = ack_ok_q ? ST_WDATA : ST_IDLE;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (ack_end)   state_d = ack_ok_q ? ST_WDATA : ST_IDLE;
                ST_RDATA:     if (byte_done) state_d = ST_RACK;
                ST_RACK:      if (ack_end)   state_d = (m_ack_q && rd_more) ? ST_RDATA : ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath: shifting, decode decisions, pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            rx_sr_q     <= '0;
            tx_sr_q     <= 8'hFF;
            phase_q     <= 1'b0;
            ack_ok_q    <= 1'b0;
            rw_q        <= 1'b0;
            m_ack_q     <= 1'b0;
            byte_mode_q <= 1'b0;
            cnt_seen_q  <= 1'b0;
            ptr_q       <= '0;
            wcnt_q      <= '0;
            widx_q      <= '0;
            ridx_q      <= '0;
        end else if (start_ev || stop_ev) begin
            bit_cnt_q <= '0;
            phase_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise) begin
                        rx_sr_q   <= rx_byte[6:0];
                        bit_cnt_q <= bit_cnt_q + 3'd1;
                    end
                    if (byte_done) begin
                        phase_q <= 1'b0;
                        if (state_q == ST_ADDR) begin
                            ack_ok_q <= (rx_byte[7:1] == DEV_ADDR);
                            rw_q     <= rx_byte[0];
                        end else if (state_q == ST_CMD) begin
                            ack_ok_q <= cmd_ok;
                            if (cmd_ok) begin
                                byte_mode_q <= rx_byte[7];
                                ptr_q       <= rx_byte[AW-1:0];
                                cnt_seen_q  <= 1'b0;
                                widx_q      <= '0;
                            end
                        end else begin
                            ack_ok_q <= w_accept;
                            if (w_accept) begin
                                cnt_seen_q <= 1'b1;
                                if (!byte_mode_q && !cnt_seen_q) wcnt_q <= rx_byte;
                                if (!byte_mode_q && cnt_seen_q)  widx_q <= widx_q + 8'd1;
                            end
                        end
                    end
                end
                ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        if (!phase_q) phase_q <= 1'b1;
                        else begin
                            phase_q   <= 1'b0;
                            bit_cnt_q <= '0;
                            if (state_q == ST_ADDR_ACK && ack_ok_q && rw_q) begin
                                tx_sr_q <= byte_mode_q ? rdata : NREG8;
                                ridx_q  <= '0;
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bit_cnt_q <= bit_cnt_q + 3'd1;
                        if (bit_cnt_q == 3'd7) phase_q <= 1'b0;
                    end else if (scl_fall) begin
                        tx_sr_q <= {tx_sr_q[6:0], 1'b1};
                    end
                end
                ST_RACK: begin
                    if (scl_rise) m_ack_q <= ~sda_s;
                    if (scl_fall) begin
                        if (!phase_q) phase_q <= 1'b1;
                        else begin
                            phase_q   <= 1'b0;
                            bit_cnt_q <= '0;
                            if (m_ack_q && rd_more) begin
                                tx_sr_q <= rdata;
                                ridx_q  <= ridx_q + RW'(1);
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // output logic
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe = phase_q & ack_ok_q;
            ST_RDATA:                              sda_oe = ~tx_sr_q[7];
            ST_RACK:                               sda_oe = ~phase_q & ~tx_sr_q[7];
            default:                               sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
    parameter int unsigned       NREG     = 8,
    parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic [NREG*8-1:0] regs_o,
    input logic              rise_ev,
    input logic              stop_ev
);
    // R1: reset loads the default image and releases the line
    a_r1_reset_defaults: assert property (@(posedge clk)
        !rst_n |=> (regs_o == DEFAULTS && !sda_oe));

    // R9: the data line is only moved while the clock line is low
    a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R11: a STOP leaves the line released
    a_r11_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    // R11: the bank only changes on the edge that completes a bit
    a_r11_commit_on_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> $past(rise_ev));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG), .DEFAULTS(DEFAULTS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe),
    .regs_o  (regs_o),
    .rise_ev (scl_rise),
    .stop_ev (stop_ev)
);

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;
    localparam int NREG       = 8;
    localparam int WATCHDOG   = 150000;
    localparam logic [NREG*8-1:0] DEFV = 64'h81A53CC3F00FE718;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
    logic hold_cmp = 1'b0, done = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] regs_o;
    wire  sda_line = sda_m & ~sda_oe;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mref [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_cfg_slave #(.NREG(NREG), .DEV_ADDR(7'h69), .DEFAULTS(DEFV)) u_smb_cfg_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .regs_o (regs_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] mflat();
        logic [NREG*8-1:0] f;
        for (int k = 0; k < NREG; k++) f[k*8 +: 8] = mref[k];
        return f;
    endfunction

    // reference bank compared every clock, away from both edges
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (rst_n && !hold_cmp && !done)
            chk(regs_o == mflat(), "R5/R6 bank vs model", regs_o, mflat());
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(H); scl = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl = 1'b0; wt(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(2);
    endtask

    task automatic write_byte(input logic [7:0] b, input bit exp_ack, input int midx, input string req);
        logic got;
        for (int i = 7; i >= 0; i--) begin
            if (i == 0 && midx >= 0) hold_cmp = 1'b1;
            send_bit(b[i]);
        end
        sda_m = 1'b1; wt(H); scl = 1'b1; wt(H/2); got = ~sda_line; wt(H/2); scl = 1'b0; wt(2);
        chk(got == exp_ack, req, 64'(got), 64'(exp_ack));
        if (midx >= 0 && exp_ack) mref[midx] = b;
        hold_cmp = 1'b0;
    endtask

    task automatic read_byte(input logic [7:0] exp, input bit mack, input string req);
        logic [7:0] got;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H); scl = 1'b1; wt(H/2); got[i] = sda_line; wt(H/2); scl = 1'b0; wt(2);
        end
        sda_m = ~mack; wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(2); sda_m = 1'b1;
        chk(got == exp, req, 64'(got), 64'(exp));
    endtask

    initial begin
        for (int k = 0; k < NREG; k++) mref[k] = DEFV[k*8 +: 8];
        wt(5);
        rst_n = 1'b1;
        wt(3);
        chk(regs_o == DEFV, "R1 reset image", regs_o, DEFV);
        chk(sda_oe == 1'b0, "R1 line released", 64'(sda_oe), 64'd0);

        // R2: foreign address is NACKed
        bus_start(); write_byte(8'hA0, 1'b0, -1, "R2 foreign address nack"); bus_stop();

        // R5: byte write then an extra byte
        bus_start(); write_byte(8'hD2, 1'b1, -1, "R2 own address ack");
        write_byte(8'h82, 1'b1, -1, "R3 byte command ack");
        write_byte(8'h5A, 1'b1, 2, "R5 byte write ack");
        write_byte(8'h77, 1'b0, -1, "R5 extra byte nack"); bus_stop();

        // R3: offset past the bank
        bus_start(); write_byte(8'hD2, 1'b1, -1, "R2 own address ack");
        write_byte(8'h88, 1'b0, -1, "R3 offset out of range nack"); bus_stop();

        // R4: block command with non-zero low bits
        bus_start(); write_byte(8'hD2, 1'b1, -1, "R2 own address ack");
        write_byte(8'h05, 1'b0, -1, "R4 bad block command nack"); bus_stop();

        // R6: block write limited by its count
        bus_start(); write_byte(8'hD2, 1'b1, -1, "R2 own address ack");
        write_byte(8'h00, 1'b1, -1, "R4 block command ack");
        write_byte(8'h03, 1'b1, -1, "R6 count ack");
        write_byte(8'h11, 1'b1, 0, "R6 block byte 0");
        write_byte(8'h22, 1'b1, 1, "R6 block byte 1");
        write_byte(8'h33, 1'b1, 2, "R6 block byte 2");
        write_byte(8'h44, 1'b0, -1, "R6 past count nack"); bus_stop();

        // R6: block write limited by the bank size
        bus_start(); write_byte(8'hD2, 1'b1, -1, "R2 own address ack");
        write_byte(8'h00, 1'b1, -1, "R4 block command ack");
        write_byte(8'd20, 1'b1, -1, "R6 count ack");
        for (int k = 0; k < NREG; k++) write_byte(8'hA0 + 8'(k), 1'b1, k, "R6 block byte");
        write_byte(8'hEE, 1'b0, -1, "R6 past bank nack"); bus_stop();

        // R10: stop after two complete bytes keeps them
        bus_start(); write_byte(8'hD2, 1'b1, -1, "R2 own address ack");
        write_byte(8'h00, 1'b1, -1, "R4 block command ack");
        write_byte(8'h05, 1'b1, -1, "R6 count ack");
        write_byte(8'hC1, 1'b1, 0, "R10 kept byte 0");
        write_byte(8'h3E, 1'b1, 1, "R10 kept byte 1"); bus_stop();
        chk(regs_o[15:0] == 16'h3EC1, "R10 bytes kept after stop", 64'(regs_o[15:0]), 64'h3EC1);

        // R7: byte read through repeated start
        bus_start(); write_byte(8'hD2, 1'b1, -1, "R2 own address ack");
        write_byte(8'h85, 1'b1, -1, "R3 byte command ack");
        bus_start(); write_byte(8'hD3, 1'b1, -1, "R2 read address ack");
        read_byte(mref[5], 1'b0, "R7 R9 byte read offset 5"); bus_stop();
        chk(sda_oe == 1'b0, "R7 line released after read", 64'(sda_oe), 64'd0);

        // R8: full block read
        bus_start(); write_byte(8'hD2, 1'b1, -1, "R2 own address ack");
        write_byte(8'h00, 1'b1, -1, "R4 block command ack");
        bus_start(); write_byte(8'hD3, 1'b1, -1, "R2 read address ack");
        read_byte(8'(NREG), 1'b1, "R8 count byte");
        for (int k = 0; k < NREG; k++) read_byte(mref[k], k != NREG-1, "R8 R9 block read byte");
        bus_stop();

        // R8: block read ended early by controller NACK
        bus_start(); write_byte(8'hD3, 1'b1, -1, "R2 read address ack");
        read_byte(8'(NREG), 1'b1, "R8 count byte");
        read_byte(mref[0], 1'b1, "R8 early byte 0");
        read_byte(mref[1], 1'b0, "R8 early byte 1"); bus_stop();
        chk(sda_oe == 1'b0, "R8 line released after nack", 64'(sda_oe), 64'd0);

        // R2: foreign read address
        bus_start(); write_byte(8'hD5, 1'b0, -1, "R2 foreign read nack"); bus_stop();

        // R11: STOP inside a data byte
        bus_start(); write_byte(8'hD2, 1'b1, -1, "R2 own address ack");
        write_byte(8'h83, 1'b1, -1, "R3 byte command ack");
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        chk(regs_o[31:24] == mref[3], "R11 stop abort no commit", 64'(regs_o[31:24]), 64'(mref[3]));
        chk(sda_oe == 1'b0, "R11 stop abort released", 64'(sda_oe), 64'd0);

        // R11: START inside a data byte, then a fresh transaction
        bus_start(); write_byte(8'hD2, 1'b1, -1, "R2 own address ack");
        write_byte(8'h83, 1'b1, -1, "R3 byte command ack");
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        bus_start(); write_byte(8'hD2, 1'b1, -1, "R11 fresh address after abort");
        write_byte(8'h83, 1'b1, -1, "R3 byte command ack");
        write_byte(8'h3C, 1'b1, 3, "R11 write after abort"); bus_stop();
        chk(regs_o[31:24] == 8'h3C, "R11 write after abort lands", 64'(regs_o[31:24]), 64'h3C);

        wt(20);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule